// File: doc/BRIEF.md
# Load-Use Stall Controller

This block guards an in-order five-stage pipeline against the one hazard that forwarding cannot cover. A load only has its data at the end of the memory stage. An instruction that follows it directly and reads the loaded register would need that value one cycle too early. The block compares the execute-stage load against the source registers of the instruction in decode. On a match it holds fetch and decode for one cycle and sends an empty slot into execute. After that cycle the loaded value can reach the delayed consumer from the memory/writeback latch.

The block includes a small two-register pipeline wrapper: a fetch-to-decode latch and a decode-to-execute latch. This lets the stall, the held decode slot and the injected bubble be seen over several cycles. Decoded instruction fields arrive on a valid/ready stream.

Back-pressure rules for that stream:
- `fetch_ready` is low exactly in a stall cycle.
- While `fetch_valid` is high and `fetch_ready` is low, the producer must keep the same fields on the stream.
- A beat is taken on a clock edge where both `fetch_valid` and `fetch_ready` are high.
- If `fetch_valid` is low while `fetch_ready` is high, an empty slot enters decode.

Top module: `lu_stall_top`

## Requirements
- R1: `bubble` is high in a cycle exactly when all of these hold:
  - the execute slot is valid and is a load (`ex_load`=1) with a nonzero destination;
  - the decode slot is valid;
  - a source that the decode slot marks as used (`use1` for source 1, `use2` for source 2) equals that destination.
- R2: Each load-use pair costs exactly one stall cycle. In the cycle after a stall, the same decode instruction moves on without a second stall.
- R3: In a stall cycle `pc_we` and `fetch_ready` are low, and no fetch beat is taken. In any other cycle both are high.
- R4: In a stall cycle `ifid_we` is low, and the decode slot (`id_valid`, `id_tag`) is unchanged in the next cycle. Otherwise `ifid_we` is high.
- R5: In the cycle after a stall, the execute slot is entirely zero: `ex_valid`, `ex_load`, `ex_wr`, `ex_rd` and `ex_tag` are all 0.
- R6: A load whose consumer is two instructions behind it causes no stall.
- R7: A load whose destination is register 0 causes no stall.
- R8: A match on a source whose use flag is 0 causes no stall.
- R9: A non-load producer (`fetch_load`=0) followed directly by a reader of its destination causes no stall.
- R10: After reset the decode and execute slots are empty and `bubble` is low.
- R11: A cycle with `fetch_valid` low and `fetch_ready` high puts an empty slot (`id_valid`=0) into decode. Because of that gap, a load and its consumer end up two slots apart, and no stall is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | Fetch beat present |
| fetch_ready | output | 1 | Fetch beat accepted this cycle |
| fetch_tag | input | TAG_W | Instruction identifier |
| fetch_rd | input | REG_W | Destination register index |
| fetch_rs1 | input | REG_W | Source 1 index |
| fetch_rs2 | input | REG_W | Source 2 index |
| fetch_use1 | input | 1 | Source 1 is read |
| fetch_use2 | input | 1 | Source 2 is read |
| fetch_load | input | 1 | Instruction is a load |
| fetch_wr | input | 1 | Instruction writes a register |
| pc_we | output | 1 | Program counter may advance |
| ifid_we | output | 1 | Fetch/decode latch may load |
| bubble | output | 1 | Zero the decode/execute latch |
| id_valid | output | 1 | Decode slot occupied |
| id_tag | output | TAG_W | Decode slot identifier |
| ex_valid | output | 1 | Execute slot occupied |
| ex_tag | output | TAG_W | Execute slot identifier |
| ex_rd | output | REG_W | Execute slot destination |
| ex_load | output | 1 | Execute slot is a load |
| ex_wr | output | 1 | Execute slot writes a register |

## Verification
The bench targets these corner cases, each with the failure it would expose:
- A match on the second source only. A design comparing only the first source would let the consumer read stale data.
- A consumer that reads the loaded register through both sources. A design that counts matches instead of OR-ing them would stall twice.
- Two loads in a row, where the second load consumes the first. This chains two single stalls; a controller that does not re-evaluate every cycle would miss the second stall or merge the two.
- Register 0, unused sources, ALU producers and a load two slots ahead, including a gap slot from an idle fetch. Each must give zero stalls; a wrong design would waste a cycle or hold the stream.

// File: rtl/lu_pkg.sv
package lu_pkg;
  parameter int unsigned LU_REG_W = 5;
  parameter int unsigned LU_TAG_W = 8;
  parameter int unsigned LU_NSRC  = 2;

  typedef enum logic {
    PIPE_RUN  = 1'b0,
    PIPE_HOLD = 1'b1
  } pipe_mode_e;
endpackage

// File: rtl/lu_hazard_detect.sv
module lu_hazard_detect #(
  parameter int unsigned REG_W = lu_pkg::LU_REG_W,
  parameter int unsigned NSRC  = lu_pkg::LU_NSRC
) (
  input  logic                       ex_valid,
  input  logic                       ex_load,
  input  logic [REG_W-1:0]           ex_rd,
  input  logic                       id_valid,
  input  logic [NSRC-1:0][REG_W-1:0] id_src,
  input  logic [NSRC-1:0]            id_use,
  output logic                       stall
);
  logic [NSRC-1:0] src_hit;
  logic            producer_live;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    assign src_hit[s] = id_use[s] && (id_src[s] == ex_rd);
  end

  assign producer_live = ex_valid && ex_load && (ex_rd != '0);
  assign stall         = producer_live && id_valid && (|src_hit);

  always_comb begin
    // R7
    if (ex_rd == '0) begin
      rd0_nostall_chk: assert (!stall);
    end
  end
endmodule

// File: rtl/lu_stage_reg.sv
module lu_stage_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic         clr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else if (we)  q <= d;
  end

  // R4
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!we && !clr) |=> (q == $past(q)));

  // R5
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q == '0));
endmodule

// File: rtl/lu_stall_top.sv
module lu_stall_top #(
  parameter int unsigned REG_W = lu_pkg::LU_REG_W,
  parameter int unsigned TAG_W = lu_pkg::LU_TAG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch_valid,
  output logic             fetch_ready,
  input  logic [TAG_W-1:0] fetch_tag,
  input  logic [REG_W-1:0] fetch_rd,
  input  logic [REG_W-1:0] fetch_rs1,
  input  logic [REG_W-1:0] fetch_rs2,
  input  logic             fetch_use1,
  input  logic             fetch_use2,
  input  logic             fetch_load,
  input  logic             fetch_wr,
  output logic             pc_we,
  output logic             ifid_we,
  output logic             bubble,
  output logic             id_valid,
  output logic [TAG_W-1:0] id_tag,
  output logic             ex_valid,
  output logic [TAG_W-1:0] ex_tag,
  output logic [REG_W-1:0] ex_rd,
  output logic             ex_load,
  output logic             ex_wr
);
  import lu_pkg::*;

  localparam int unsigned NSRC = 2;

  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic [REG_W-1:0] rd;
    logic [REG_W-1:0] rs2;
    logic [REG_W-1:0] rs1;
    logic             u2;
    logic             u1;
    logic             ld;
    logic             wr;
    logic             v;
  } slot_t;

  localparam int unsigned SLOT_W = $bits(slot_t);

  slot_t      if_slot, id_slot, ex_slot;
  logic       stall;
  pipe_mode_e mode;
  logic [NSRC-1:0][REG_W-1:0] id_src;
  logic [NSRC-1:0]            id_use;

  always_comb begin
    if_slot = '0;
    if (fetch_valid) begin
      if_slot.tag = fetch_tag;
      if_slot.rd  = fetch_rd;
      if_slot.rs1 = fetch_rs1;
      if_slot.rs2 = fetch_rs2;
      if_slot.u1  = fetch_use1;
      if_slot.u2  = fetch_use2;
      if_slot.ld  = fetch_load;
      if_slot.wr  = fetch_wr;
      if_slot.v   = 1'b1;
    end
  end

  assign id_src = {id_slot.rs2, id_slot.rs1};
  assign id_use = {id_slot.u2, id_slot.u1};

  lu_hazard_detect #(.REG_W(REG_W), .NSRC(NSRC)) u_detect (
    .ex_valid (ex_slot.v),
    .ex_load  (ex_slot.ld),
    .ex_rd    (ex_slot.rd),
    .id_valid (id_slot.v),
    .id_src   (id_src),
    .id_use   (id_use),
    .stall    (stall)
  );

  assign mode        = stall ? PIPE_HOLD : PIPE_RUN;
  assign pc_we       = (mode == PIPE_RUN);
  assign ifid_we     = (mode == PIPE_RUN);
  assign fetch_ready = (mode == PIPE_RUN);
  assign bubble      = (mode == PIPE_HOLD);

  lu_stage_reg #(.W(SLOT_W)) u_ifid (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ifid_we),
    .clr   (1'b0),
    .d     (SLOT_W'(if_slot)),
    .q     (id_slot)
  );

  lu_stage_reg #(.W(SLOT_W)) u_idex (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (1'b1),
    .clr   (bubble),
    .d     (SLOT_W'(id_slot)),
    .q     (ex_slot)
  );

  assign id_valid = id_slot.v;
  assign id_tag   = id_slot.tag;
  assign ex_valid = ex_slot.v;
  assign ex_tag   = ex_slot.tag;
  assign ex_rd    = ex_slot.rd;
  assign ex_load  = ex_slot.ld;
  assign ex_wr    = ex_slot.wr;

  // R2
  single_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bubble |=> !bubble);

  // R1
  stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bubble |-> (ex_load && ex_valid && id_valid));

  // R3
  no_fetch_in_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bubble |-> (!pc_we && !fetch_ready));
endmodule

// File: tb/tb_lu_stall_top.sv
module tb_lu_stall_top;
  typedef struct packed {
    logic       v;
    logic [7:0] tag;
    logic [4:0] rd, rs1, rs2;
    logic       u1, u2, ld, wr;
  } ins_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fetch_valid = 1'b0;
  logic fetch_ready;
  logic [7:0] fetch_tag = '0;
  logic [4:0] fetch_rd = '0, fetch_rs1 = '0, fetch_rs2 = '0;
  logic fetch_use1 = 1'b0, fetch_use2 = 1'b0, fetch_load = 1'b0, fetch_wr = 1'b0;
  logic pc_we, ifid_we, bubble, id_valid, ex_valid, ex_load, ex_wr;
  logic [7:0] id_tag, ex_tag;
  logic [4:0] ex_rd;

  always #10 clk = ~clk;

  lu_stall_top dut (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
    .fetch_tag(fetch_tag), .fetch_rd(fetch_rd), .fetch_rs1(fetch_rs1), .fetch_rs2(fetch_rs2),
    .fetch_use1(fetch_use1), .fetch_use2(fetch_use2), .fetch_load(fetch_load), .fetch_wr(fetch_wr),
    .pc_we(pc_we), .ifid_we(ifid_we), .bubble(bubble), .id_valid(id_valid), .id_tag(id_tag),
    .ex_valid(ex_valid), .ex_tag(ex_tag), .ex_rd(ex_rd), .ex_load(ex_load), .ex_wr(ex_wr)
  );

  ins_t q[$];
  ins_t mid = '0, mex = '0;
  int pass_n = 0, fail_n = 0, stall_seen = 0;
  bit hold = 0;
  int tagc = 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    if (ok) pass_n++;
    else begin
      fail_n++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic ins_t mk(input int rd, input int rs1, input int rs2,
                              input bit u1, input bit u2, input bit ld, input bit wr);
    ins_t i;
    i.v = 1'b1; i.tag = 8'(tagc); i.rd = 5'(rd); i.rs1 = 5'(rs1); i.rs2 = 5'(rs2);
    i.u1 = u1; i.u2 = u2; i.ld = ld; i.wr = wr;
    tagc++;
    return i;
  endfunction

  function automatic bit m_stall();
    return mex.v && mex.ld && (mex.rd != 0) && mid.v &&
           ((mid.u1 && mid.rs1 == mex.rd) || (mid.u2 && mid.rs2 == mex.rd));
  endfunction

  task automatic step(input bit gap);
    ins_t f;
    bit fv, s;
    @(negedge clk);
    fv = (q.size() > 0) && (hold || !gap);
    f = fv ? q[0] : '0;
    fetch_valid = fv; fetch_tag = f.tag; fetch_rd = f.rd; fetch_rs1 = f.rs1; fetch_rs2 = f.rs2;
    fetch_use1 = f.u1; fetch_use2 = f.u2; fetch_load = f.ld; fetch_wr = f.wr;
    #1;
    s = m_stall();
    chk(bubble === s, "R1 bubble", int'(bubble), int'(s));
    chk(pc_we === !s && fetch_ready === !s, "R3 pc_we/fetch_ready", int'(pc_we), int'(!s));
    // R4 / R11: decode slot contents and hold
    chk(ifid_we === !s && id_valid === mid.v && id_tag === mid.tag, "R4 decode slot",
        int'(id_tag), int'(mid.tag));
    // R5: execute slot, zero after a bubble
    chk(ex_valid === mex.v && ex_tag === mex.tag && ex_rd === mex.rd &&
        ex_load === mex.ld && ex_wr === mex.wr, "R5 execute slot", int'(ex_tag), int'(mex.tag));
    if (s) stall_seen++;
    if (s) mex = '0;
    else begin
      mex = mid;
      mid = fv ? f : '0;
    end
    hold = fv && s;
    if (fv && !s) void'(q.pop_front());
  endtask

  task automatic run_case(input string req, input int exp_stalls, input bit gap_after_first);
    int n;
    stall_seen = 0;
    n = 0;
    while (q.size() > 0) begin
      step(gap_after_first && n == 1);
      n++;
    end
    repeat (4) step(0);
    chk(stall_seen == exp_stalls, req, stall_seen, exp_stalls);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    fail_n++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", pass_n, pass_n + fail_n);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10
    chk(!id_valid && !ex_valid && !bubble && pc_we, "R10 reset state", int'(bubble), 0);

    // R1: load then first-source reader
    q.push_back(mk(5, 0, 0, 0, 0, 1, 1)); q.push_back(mk(9, 5, 2, 1, 1, 0, 1));
    run_case("R1 src1 stall count", 1, 0);
    // R1: second-source match only
    q.push_back(mk(7, 0, 0, 0, 0, 1, 1)); q.push_back(mk(9, 3, 7, 1, 1, 0, 1));
    run_case("R1 src2 stall count", 1, 0);
    // R2: both sources match, still one stall
    q.push_back(mk(3, 0, 0, 0, 0, 1, 1)); q.push_back(mk(9, 3, 3, 1, 1, 0, 1));
    run_case("R2 single stall", 1, 0);
    // R2: chained loads, two separate stalls
    q.push_back(mk(4, 0, 0, 0, 0, 1, 1)); q.push_back(mk(6, 4, 0, 1, 0, 1, 1));
    q.push_back(mk(9, 6, 0, 1, 0, 0, 1));
    run_case("R2 chained stalls", 2, 0);
    // R6: consumer two behind
    q.push_back(mk(5, 0, 0, 0, 0, 1, 1)); q.push_back(mk(8, 1, 2, 1, 1, 0, 1));
    q.push_back(mk(9, 5, 0, 1, 0, 0, 1));
    run_case("R6 two ahead", 0, 0);
    // R7: load to register 0
    q.push_back(mk(0, 0, 0, 0, 0, 1, 1)); q.push_back(mk(9, 0, 0, 1, 1, 0, 1));
    run_case("R7 reg0", 0, 0);
    // R8: match on unused sources
    q.push_back(mk(5, 0, 0, 0, 0, 1, 1)); q.push_back(mk(9, 5, 5, 0, 0, 0, 1));
    run_case("R8 unused src", 0, 0);
    // R9: ALU producer
    q.push_back(mk(5, 0, 0, 0, 0, 0, 1)); q.push_back(mk(9, 5, 5, 1, 1, 0, 1));
    run_case("R9 alu producer", 0, 0);
    // R11: fetch gap separates load and reader
    q.push_back(mk(5, 0, 0, 0, 0, 1, 1)); q.push_back(mk(9, 5, 0, 1, 0, 0, 1));
    run_case("R11 gap slot", 0, 1);

    // random traffic against the cycle model
    for (int k = 0; k < 400; k++) begin
      q.push_back(mk($urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7),
                     1'($urandom), 1'($urandom), ($urandom_range(0, 2) == 0), 1'b1));
    end
    while (q.size() > 0) step($urandom_range(0, 3) == 0);
    repeat (4) step(0);

    $display("%0d/%0d checks passed", pass_n, pass_n + fail_n);
    $finish;
  end
endmodule